// File: doc/BRIEF.md
# Power-On Reset and Output Gating Sequencer

This block decides when a converter's digital output may carry real data after power is applied or after a power-down request ends. A supply-good input, driven by analog voltage sensing outside the block, keeps the internal reset asserted while it is low. After it rises, the reset is held for a fixed count of system clocks. After the reset is released, the output is still kept at zero until a settling window has passed. That window is counted in sample strobes, one strobe per sample period. When the window ends, the block raises an output-valid flag, and downstream logic uses this flag to pass data through instead of zeros.

A separate active-low power-down input stops all operation. It disables the data output driver and holds the core in reset, and clocks and strobes have no effect while it is low. When the input is released, the whole sequence runs again from the start.

The controller has four states:
- SEQ_HOLD: reset is counted in system clocks. This is also the state forced while supply is low.
- SEQ_SETTLE: reset is released, strobes are counted, and the output stays at zero.
- SEQ_RUN: data is valid.
- SEQ_SLEEP: powered down.

Transitions:
- HOLD→SETTLE when the clock count completes.
- SETTLE→RUN on the strobe that completes the sample count.
- Any state→SLEEP when the synchronized power-down request is seen.
- SLEEP→HOLD when the request is withdrawn.
- Any state→HOLD at once, without a clock edge, when supply-good falls.

Both asynchronous inputs pass through synchronizers of SYNC_STAGES flops. Supply-good asserts reset asynchronously and releases it synchronously.

Top module: `por_seq_gate`

## Requirements
- R1: Whenever supply_ok is low, core_rst is 1 and data_valid is 0 at once, without waiting for a clock edge. This holds even if the block was in the data-valid state.
- R2: Take the first rising clock edge that samples supply_ok high as edge 1, with sleep_n high. Then core_rst is high after edges 1 to SYNC_STAGES+HOLD_CYCLES-1 and low after edge SYNC_STAGES+HOLD_CYCLES.
- R3: data_valid is 0 for as long as core_rst is 1 and throughout the settling window. Strobes sampled while core_rst is 1 are not counted toward the settling window.
- R4: Once core_rst is low, data_valid rises after the clock edge that samples the SETTLE_SAMPLES-th strobe. It does not rise earlier, whatever the spacing of the strobes.
- R5: Once high, data_valid stays high through further strobes and idle cycles until supply_ok falls or a power-down takes effect.
- R6: Take the first edge that samples sleep_n low as edge 1. After edge SYNC_STAGES+1, dout_en is 0, core_rst is 1 and data_valid is 0. Before that edge the outputs are unchanged.
- R7: While sleep_n is low, clocks and strobes have no effect: core_rst stays 1, and dout_en and data_valid stay 0. After sleep_n rises, the full sequence restarts. Taking the first edge that samples it high as edge 1, core_rst falls after edge SYNC_STAGES+1+HOLD_CYCLES. After that, SETTLE_SAMPLES fresh strobes are needed.
- R8: dout_en is 1 in every state except power-down. This includes the reset hold and the time while supply_ok is low. After a wake-up, it returns after edge SYNC_STAGES+1.
- R9: A power-down that cuts off a partly counted reset hold or settling window discards the partial count. After the wake-up, the full HOLD_CYCLES and SETTLE_SAMPLES are required again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| supply_ok | input | 1 | Supply-good from external sensing, asynchronous, high when supply is above threshold |
| sleep_n | input | 1 | Power-down request, active low, asynchronous |
| sample_tick | input | 1 | One-clock strobe per sample period, synchronous to clk |
| core_rst | output | 1 | Internal reset for the converter core, active high |
| data_valid | output | 1 | High when output data may be passed; low forces zero data |
| dout_en | output | 1 | Data output driver enable; low only while powered down |

## Verification
The embedded properties check the following on every clock:
- A power-down request always disables the output one cycle after it is seen synchronized.
- The valid flag only rises on a cycle that follows a strobe.
- The valid flag persists while no power-down is pending.
- The reset only falls after the hold counter reports its last count.
- A wake-up always begins in reset.

Exact cycle counts can only be shown by the bench's scenarios. These are the release latency after supply rise and after wake-up, the strobe count that raises valid under varied spacing, the discarding of strobes seen during reset, the restart after partial counts, and the immediate, clockless effect of a supply drop.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_HOLD   = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_RUN    = 2'd2,
        SEQ_SLEEP  = 2'd3
    } seq_state_t;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/por_sync_chain.sv
module por_sync_chain #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain_q[0] <= RST_VAL;
                    else         chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain_q[i] <= RST_VAL;
                    else         chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/por_window_counter.sv
module por_window_counter
    import por_seq_pkg::*;
#(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic at_last
);
    localparam int W = cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clr)              cnt_q <= '0;
        else if (step && !at_last) cnt_q <= cnt_q + 1'b1;
    end

    assign at_last = (cnt_q == LAST);
endmodule

// File: rtl/por_seq_gate.sv
module por_seq_gate
    import por_seq_pkg::*;
#(
    parameter int HOLD_CYCLES    = 1024,
    parameter int SETTLE_SAMPLES = 4480,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic supply_ok,
    input  logic sleep_n,
    input  logic sample_tick,
    output logic core_rst,
    output logic data_valid,
    output logic dout_en
);
    logic       sup_rst_n;
    logic       sleep_s;
    logic       hold_last;
    logic       settle_last;
    seq_state_t state_q;
    seq_state_t state_d;

    // Supply-good: asynchronous assert, synchronous release
    por_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sup_sync (
        .clk    (clk),
        .arst_n (supply_ok),
        .d      (1'b1),
        .q      (sup_rst_n)
    );

    // Power-down request, idles in the "awake" value during reset
    por_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sleep_sync (
        .clk    (clk),
        .arst_n (sup_rst_n),
        .d      (sleep_n),
        .q      (sleep_s)
    );

    por_window_counter #(.LIMIT(HOLD_CYCLES)) i_hold_cnt (
        .clk     (clk),
        .rst_n   (sup_rst_n),
        .clr     (state_q != SEQ_HOLD),
        .step    (state_q == SEQ_HOLD),
        .at_last (hold_last)
    );

    por_window_counter #(.LIMIT(SETTLE_SAMPLES)) i_settle_cnt (
        .clk     (clk),
        .rst_n   (sup_rst_n),
        .clr     (state_q != SEQ_SETTLE),
        .step    ((state_q == SEQ_SETTLE) && sample_tick),
        .at_last (settle_last)
    );

    // State register
    always_ff @(posedge clk or negedge sup_rst_n) begin
        if (!sup_rst_n) state_q <= SEQ_HOLD;
        else            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_HOLD: begin
                if (!sleep_s)       state_d = SEQ_SLEEP;
                else if (hold_last) state_d = SEQ_SETTLE;
            end
            SEQ_SETTLE: begin
                if (!sleep_s)                        state_d = SEQ_SLEEP;
                else if (settle_last && sample_tick) state_d = SEQ_RUN;
            end
            SEQ_RUN: begin
                if (!sleep_s) state_d = SEQ_SLEEP;
            end
            SEQ_SLEEP: begin
                if (sleep_s) state_d = SEQ_HOLD;
            end
        endcase
    end

    // Output decode
    always_comb begin
        core_rst   = 1'b1;
        data_valid = 1'b0;
        dout_en    = 1'b1;
        unique case (state_q)
            SEQ_HOLD:   begin core_rst = 1'b1; data_valid = 1'b0; dout_en = 1'b1; end
            SEQ_SETTLE: begin core_rst = 1'b0; data_valid = 1'b0; dout_en = 1'b1; end
            SEQ_RUN:    begin core_rst = 1'b0; data_valid = 1'b1; dout_en = 1'b1; end
            SEQ_SLEEP:  begin core_rst = 1'b1; data_valid = 1'b0; dout_en = 1'b0; end
        endcase
    end

    // R6: a synchronized power-down request turns the driver off next cycle
    p_sleep_disables_r6: assert property (@(posedge clk) disable iff (!sup_rst_n)
        !sleep_s |=> !dout_en);

    // R4: valid only rises on the cycle after a sampled strobe
    p_valid_on_tick_r4: assert property (@(posedge clk) disable iff (!sup_rst_n)
        $rose(data_valid) |-> $past(sample_tick));

    // R5: valid persists while no power-down is pending
    p_valid_sticky_r5: assert property (@(posedge clk) disable iff (!sup_rst_n)
        (data_valid && sleep_s) |=> data_valid);

    // R2: reset release only after the hold counter reached its last count
    p_release_counted_r2: assert property (@(posedge clk) disable iff (!sup_rst_n)
        $fell(core_rst) |-> $past(hold_last));

    // R7: a wake-up always begins with the core still in reset
    p_wake_in_reset_r7: assert property (@(posedge clk) disable iff (!sup_rst_n)
        $rose(sleep_s) |-> core_rst);

endmodule

// File: tb/test_por_seq_gate.sv
module test_por_seq_gate;
    localparam int HOLD   = 6;
    localparam int SETTLE = 4;
    localparam int SYNC   = 2;

    logic clk = 1'b0;
    logic supply_ok = 1'b0;
    logic sleep_n = 1'b1;
    logic sample_tick = 1'b0;
    logic core_rst;
    logic data_valid;
    logic dout_en;
    int   checks = 0;
    int   errors = 0;

    always #10 clk = ~clk;

    por_seq_gate #(
        .HOLD_CYCLES    (HOLD),
        .SETTLE_SAMPLES (SETTLE),
        .SYNC_STAGES    (SYNC)
    ) i_por_seq_gate (
        .clk         (clk),
        .supply_ok   (supply_ok),
        .sleep_n     (sleep_n),
        .sample_tick (sample_tick),
        .core_rst    (core_rst),
        .data_valid  (data_valid),
        .dout_en     (dout_en)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic edge1();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic power_up(input int pre, input string req);
        supply_ok = 1'b1;
        for (int n = 1; n <= SYNC + HOLD + 1; n++) begin
            sample_tick = (n > SYNC && n <= SYNC + pre);
            edge1();
            chk(req, "core_rst release", core_rst, n < SYNC + HOLD);
            chk("R3", "data_valid in hold", data_valid, 1'b0);
        end
        sample_tick = 1'b0;
        chk("R8", "dout_en after power-up", dout_en, 1'b1);
    endtask

    task automatic settle(input int gap, input string req);
        for (int k = 1; k <= SETTLE; k++) begin
            for (int g = 0; g < gap; g++) begin
                edge1();
                chk("R3", "data_valid idle in settle", data_valid, 1'b0);
            end
            sample_tick = 1'b1;
            edge1();
            sample_tick = 1'b0;
            chk(req, "data_valid after strobe", data_valid, k == SETTLE);
        end
    endtask

    task automatic wake(input string req);
        sleep_n = 1'b1;
        for (int n = 1; n <= SYNC + 1 + HOLD + 1; n++) begin
            edge1();
            chk(req, "core_rst after wake", core_rst, n < SYNC + 1 + HOLD);
            chk("R8", "dout_en after wake", dout_en, n >= SYNC + 1);
            chk("R3", "data_valid after wake", data_valid, 1'b0);
        end
    endtask

    task automatic supply_drop();
        supply_ok = 1'b0;
        #1;
        chk("R1", "core_rst on supply drop", core_rst, 1'b1);
        chk("R1", "data_valid on supply drop", data_valid, 1'b0);
        chk("R8", "dout_en with supply low", dout_en, 1'b1);
        edge1();
        edge1();
        chk("R1", "core_rst while supply low", core_rst, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk("R1", "core_rst at start", core_rst, 1'b1);
        chk("R1", "data_valid at start", data_valid, 1'b0);
        chk("R8", "dout_en at start", dout_en, 1'b1);

        // Sweep strobe spacing and strobes injected during the hold
        for (int gap = 0; gap <= 2; gap++) begin
            for (int pre = 0; pre <= 2; pre++) begin
                power_up(pre, "R2");
                settle(gap, "R4");
                for (int x = 0; x < 3; x++) begin
                    sample_tick = 1'b1;
                    edge1();
                    sample_tick = 1'b0;
                    edge1();
                    chk("R5", "data_valid stays", data_valid, 1'b1);
                end
                supply_drop();
            end
        end

        // Power-down from the running state
        power_up(0, "R2");
        settle(1, "R4");
        sleep_n = 1'b0;
        for (int n = 1; n <= SYNC + 2; n++) begin
            edge1();
            chk("R6", "dout_en on sleep", dout_en, n < SYNC + 1);
            chk("R6", "core_rst on sleep", core_rst, n >= SYNC + 1);
            chk("R6", "data_valid on sleep", data_valid, n < SYNC + 1);
        end
        for (int n = 0; n < 12; n++) begin
            sample_tick = (n % 3 == 0);
            edge1();
            chk("R7", "core_rst asleep", core_rst, 1'b1);
            chk("R7", "dout_en asleep", dout_en, 1'b0);
            chk("R7", "data_valid asleep", data_valid, 1'b0);
        end
        sample_tick = 1'b0;
        wake("R7");
        settle(0, "R7");
        supply_drop();

        // Power-down cutting a partial hold
        supply_ok = 1'b1;
        repeat (SYNC + 3) edge1();
        sleep_n = 1'b0;
        repeat (SYNC + 1) edge1();
        chk("R9", "dout_en asleep in hold", dout_en, 1'b0);
        wake("R9");

        // Power-down cutting a partial settle
        for (int k = 1; k < SETTLE; k++) begin
            sample_tick = 1'b1;
            edge1();
            sample_tick = 1'b0;
            chk("R9", "data_valid partial settle", data_valid, 1'b0);
        end
        sleep_n = 1'b0;
        repeat (SYNC + 1) edge1();
        chk("R9", "core_rst asleep in settle", core_rst, 1'b1);
        wake("R9");
        settle(0, "R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule